// File: doc/BRIEF.md
# Sequential Shift-Add Mantissa Multiplier

This block multiplies two normalized unsigned mantissas over several clock cycles. It is one stage of a floating-point multiply datapath. Each operand is `W = WORD_W * NWORDS` bits wide and has its leading one in bit `W-1`. The two lowest bits of each operand are guard and round positions. The product is built in a `W+1`-bit accumulator, and the multiplier Y is consumed one bit per cycle, least significant bit first. In each step the accumulator first shifts right by one, and the bit that falls out is ORed into a sticky flag. Then X is added to the accumulator if the current Y bit is one.

Y is also viewed as `NWORDS` words of `WORD_W` bits. A lower word of Y that is entirely zero costs one cycle: the accumulator moves right by a whole word, and the dropped word is ORed into sticky. If the lowest word is zero, it costs no cycle at all, because the accumulator is still zero at that point. The two guard/round positions of Y are skipped at load for the same reason.

The raw product lies in [1, 4). When it reaches 2 or more, it is shifted right once to renormalize, and the dropped bit joins sticky. Exponent, sign and rounding are handled elsewhere.

Operands enter through a valid/ready pair. `in_ready` is high only while the block is idle, so the upstream holds its operands until they are taken. The result leaves through a second valid/ready pair. `out_valid` stays high, with the outputs frozen, until the consumer raises `out_ready`. No new operands are taken until that happens.

Top module: `mant_mul_seq`

## Requirements
- R1: `in_ready` is 1 exactly when no operation is running and no result is waiting. Operands are captured on a rising edge where `in_valid` and `in_ready` are both 1. After reset, `in_ready`=1 and `out_valid`=0.
- R2: With P = X*Y, the raw result is A = floor(P / 2^(W-1)). If A < 2^W, then `out_mant` = A. Otherwise, `out_mant` = floor(A/2).
- R3: `out_sticky` is 1 exactly when any bit was discarded. That means either P mod 2^(W-1) is nonzero, or a renormalization shift dropped a 1.
- R4: `out_norm` is 1 exactly when P >= 2^(2W-1), which is when the renormalizing right shift was applied.
- R5: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_mant`, `out_sticky` and `out_norm` stay unchanged. The result is released on an edge where `out_ready`=1.
- R6: Let the capture edge be edge 0. `out_valid` rises after edge N, where N is the sum of the following per-word costs:
  - lowest word of Y: 0 if it is zero, otherwise WORD_W-2;
  - each middle word: 1 if it is zero, otherwise WORD_W;
  - top word: WORD_W.
- R7: `in_valid` and the operand inputs have no effect while an operation is running or a result is waiting. The result reflects only the captured operands.
- R8: Whenever `out_valid`=1, bit W-1 of `out_mant` is 1.
- R9: The inputs must obey a contract: X[W-1]=1, Y[W-1]=1 and Y[1:0]=0 on every capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle, operands will be taken |
| in_x | input | W | Multiplicand mantissa X |
| in_y | input | W | Multiplier mantissa Y |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_mant | output | W | Normalized product mantissa |
| out_sticky | output | 1 | OR of all discarded product bits |
| out_norm | output | 1 | One-bit renormalizing right shift was applied |

## Verification
The assertions assume that every captured operand pair is normalized, with the top bit of both X and Y set, and that Y carries zeros in its guard and round positions. The word-skip decision and the end-of-run detection both rely on Y's leading one. The bench keeps to this contract by building every Y as the top bit ORed with a shifted sweep value, and every X with its top bit forced on. Operands offered while the block is busy are deliberately left outside the contract, since they must be ignored.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } mm_state_t;
endpackage

// File: rtl/mm_ctrl.sv
module mm_ctrl #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 2,
  localparam int W     = WORD_W * NWORDS,
  localparam int OFF_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_y,
  input  logic         out_ready,
  output logic         in_ready,
  output logic         out_valid,
  output logic         load,
  output logic         skip,
  output logic         step,
  output logic         last,
  output logic         y_bit
);
  import mm_pkg::*;

  mm_state_t    state_q;
  logic [W-1:0] yrem_q;   // remaining multiplier bits, current bit at [0]
  logic [OFF_W-1:0] off_q; // bit offset inside the current word
  logic         running;
  logic         word0_zero;

  assign running    = (state_q == ST_RUN);
  assign in_ready   = (state_q == ST_IDLE);
  assign out_valid  = (state_q == ST_HOLD);
  assign load       = in_ready && in_valid;
  assign word0_zero = (NWORDS > 1) && (in_y[WORD_W-1:0] == '0);

  // the leading one of Y guarantees a zero word is never the top one
  assign skip  = running && (off_q == '0) && (yrem_q[WORD_W-1:0] == '0);
  assign step  = running && !skip;
  assign y_bit = yrem_q[0];
  assign last  = step && (yrem_q == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      yrem_q  <= '0;
      off_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (in_valid) begin
          state_q <= ST_RUN;
          if (word0_zero) begin
            yrem_q <= in_y >> WORD_W;
            off_q  <= '0;
          end else begin
            yrem_q <= in_y >> 2;
            off_q  <= OFF_W'(2);
          end
        end
        ST_RUN: begin
          if (skip) begin
            yrem_q <= yrem_q >> WORD_W;
          end else begin
            yrem_q <= yrem_q >> 1;
            off_q  <= (off_q == OFF_W'(WORD_W - 1)) ? '0 : off_q + 1'b1;
          end
          if (last) state_q <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || running) |-> !in_ready);

  // R9
  in_contract_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (in_y[W-1] && (in_y[1:0] == 2'b00)));

  // R6
  run_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && yrem_q == '0) |-> 1'b0);
endmodule

// File: rtl/mm_datapath.sv
module mm_datapath #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 2,
  localparam int W     = WORD_W * NWORDS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         skip,
  input  logic         step,
  input  logic         last,
  input  logic         y_bit,
  input  logic [W-1:0] in_x,
  output logic [W-1:0] out_mant,
  output logic         out_sticky,
  output logic         out_norm
);
  logic [W-1:0] x_q;
  logic [W:0]   acc_q;
  logic         st_q;
  logic [W:0]   acc_step;
  logic         st_step;

  // shift first, then conditionally add; carry lands in acc bit W
  assign acc_step = (acc_q >> 1) + ((W+1)'(y_bit ? x_q : '0));
  assign st_step  = st_q | acc_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q        <= '0;
      acc_q      <= '0;
      st_q       <= 1'b0;
      out_mant   <= '0;
      out_sticky <= 1'b0;
      out_norm   <= 1'b0;
    end else begin
      if (load) begin
        x_q   <= in_x;
        acc_q <= '0;
        st_q  <= 1'b0;
      end else if (skip) begin
        acc_q <= acc_q >> WORD_W;
        st_q  <= st_q | (|acc_q[WORD_W-1:0]);
      end else if (step) begin
        acc_q <= acc_step;
        st_q  <= st_step;
      end
      if (last) begin
        if (acc_step[W]) begin
          out_mant   <= acc_step[W:1];
          out_sticky <= st_step | acc_step[0];
          out_norm   <= 1'b1;
        end else begin
          out_mant   <= acc_step[W-1:0];
          out_sticky <= st_step;
          out_norm   <= 1'b0;
        end
      end
    end
  end

  // R3
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) && !$past(load)) |-> st_q);
endmodule

// File: rtl/mant_mul_seq.sv
module mant_mul_seq #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 2,
  localparam int W     = WORD_W * NWORDS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_x,
  input  logic [W-1:0] in_y,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_mant,
  output logic         out_sticky,
  output logic         out_norm
);
  logic load, skip, step, last, y_bit;

  mm_ctrl #(.WORD_W(WORD_W), .NWORDS(NWORDS)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_y      (in_y),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load      (load),
    .skip      (skip),
    .step      (step),
    .last      (last),
    .y_bit     (y_bit)
  );

  mm_datapath #(.WORD_W(WORD_W), .NWORDS(NWORDS)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .skip       (skip),
    .step       (step),
    .last       (last),
    .y_bit      (y_bit),
    .in_x       (in_x),
    .out_mant   (out_mant),
    .out_sticky (out_sticky),
    .out_norm   (out_norm)
  );

  // R9
  x_contract_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> in_x[W-1]);

  // R8
  mant_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mant[W-1]);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mant)
      && $stable(out_sticky) && $stable(out_norm)));
endmodule

// File: tb/mant_mul_seq_tb.sv
module mant_mul_seq_tb_top;
  localparam int WORD_W = 3;
  localparam int NWORDS = 3;
  localparam int W      = WORD_W * NWORDS;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_x = '0;
  logic [W-1:0] in_y = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_mant;
  logic         out_sticky;
  logic         out_norm;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mant_mul_seq #(.WORD_W(WORD_W), .NWORDS(NWORDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .out_valid(out_valid), .out_ready(out_ready),
    .out_mant(out_mant), .out_sticky(out_sticky), .out_norm(out_norm)
  );

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_latency(input logic [W-1:0] y);
    int n = 0;
    for (int k = 0; k < NWORDS; k++) begin
      logic [WORD_W-1:0] wd = y[k*WORD_W +: WORD_W];
      if (k == 0)               n += (wd == '0) ? 0 : WORD_W - 2;
      else if (k == NWORDS - 1) n += WORD_W;
      else                      n += (wd == '0) ? 1 : WORD_W;
    end
    return n;
  endfunction

  task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y,
                        input bit garble, input bit backpress);
    logic [2*W-1:0] p;
    logic [W:0]     a;
    logic [W-1:0]   e_mant;
    logic           e_st, e_norm;
    int             cnt;
    p      = (2*W)'(x) * (2*W)'(y);
    a      = (W+1)'(p >> (W - 1));
    e_st   = |p[W-2:0];
    e_norm = a[W];
    if (e_norm) begin
      e_mant = a[W:1];
      e_st   = e_st | a[0];
    end else begin
      e_mant = a[W-1:0];
    end
    @(negedge clk);
    in_x = x; in_y = y; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (garble) begin
      in_x = ~x; in_y = {W{1'b1}} ^ y;   // R7 ignored operands while busy
    end else begin
      in_valid = 1'b0;
    end
    cnt = 0;
    while (cnt < 100) begin
      @(posedge clk); cnt++;
      #1;
      if (out_valid) break;
    end
    chk("R6", cnt == exp_latency(y), cnt, exp_latency(y));
    chk("R1", !in_ready, in_ready, 0);
    chk("R2", out_mant == e_mant, out_mant, e_mant);
    chk("R3", out_sticky == e_st, out_sticky, e_st);
    chk("R4", out_norm == e_norm, out_norm, e_norm);
    chk("R8", out_mant[W-1], out_mant[W-1], 1);
    if (backpress) begin
      repeat (3) @(posedge clk);
      #1;
      chk("R5", out_valid && out_mant == e_mant && out_sticky == e_st, out_mant, e_mant);
      if (garble) chk("R7", !in_ready && out_mant == e_mant, out_mant, e_mant);
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk("R1", in_ready && !out_valid, in_ready, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", in_ready == 1'b1 && out_valid == 1'b0, in_ready, 1);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 33; k++) begin
      logic [W-1:0] x;
      x = (k == 32) ? {W{1'b1}} : W'(256 + k * 8 + (k % 8));
      for (int j = 0; j < 64; j++) begin
        logic [W-1:0] y;
        y = W'(256) | W'(j << 2);
        run_op(x, y, ((j + k) % 7) == 0, (j % 11) == 0);
      end
    end
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule